// File: doc/BRIEF.md
# Memory Card Byte-Lane Steering Front End

This block sits between the 16-bit host bus of a removable memory card and a 16-bit-wide internal storage array. Every clock it samples the host's active-low strobes: a space select (high picks common memory, low picks attribute memory), two byte-lane enables, a read strobe and a write strobe, plus byte-address bit 0. From the two enables it derives one of four lane modes. Byte mode moves one byte on the low lane, and address bit 0 picks the half of the word. Word mode moves full 16-bit words. Odd mode moves only the high byte, on the high lane. Idle mode leaves the bus undriven.

Read data is returned on registered output-data and per-lane output-enable vectors one clock after the strobes are sampled. Write data is held while the write strobe is low. It is handed to the array as a one-cycle write pulse with byte strobes once the strobe is seen high again. Attribute storage is one byte per word, kept in the low half of each array word. It only ever uses the low lane and can only be written in byte mode at even addresses.

Top module: `card_lane_steer`

## Requirements
- R1: During and directly after reset, host_doe is 2'b00, host_dout is zero and arr_we is low.
- R2: The array word address is always host_addr[ADDR_W-1:1]. In byte mode (host_en_lo_n low, host_en_hi_n high), a common read with host_addr[0]=0 puts array bits [7:0] on host_dout[7:0], and host_addr[0]=1 puts bits [15:8] there. host_doe is 2'b01.
- R3: In word mode (both enables low), a common read puts the whole array word on host_dout with host_doe 2'b11, whatever host_addr[0] is.
- R4: In odd mode (host_en_lo_n high, host_en_hi_n low), a common read puts array bits [15:8] on host_dout[15:8] with host_doe 2'b10, whatever host_addr[0] is.
- R5: A lane is driven only if, on the sampled cycle, host_rd_n was low, host_wr_n was high and the mode was not idle (both enables high). Any lane not driven reads as zero on host_dout.
- R6: An attribute read (host_space_n low) never drives the high lane. In byte mode it returns array bits [7:0] on the low lane when host_addr[0]=0, and 8'hFF when host_addr[0]=1. In word mode it returns array bits [7:0] on the low lane. In odd mode it drives no lane.
- R7: A write is taken from the last sampled cycle with host_wr_n low, and is issued as a one-cycle arr_we pulse in the clock after host_wr_n is first sampled high again. For common writes, byte mode gives strobe 2'b01 (host_addr[0]=0) or 2'b10 (host_addr[0]=1) with data {din[7:0],din[7:0]}. Word mode gives strobe 2'b11 with din. Odd mode gives strobe 2'b10 with {din[15:8],din[15:8]}. arr_wattr is the inverse of host_space_n.
- R8: An attribute write is issued only in byte mode with host_addr[0]=0, with strobe 2'b01. All other attribute writes are dropped.
- R9: A cycle with host_rd_n and host_wr_n both low drives no lane and, if it is the last low cycle of the write strobe, no write is issued. A write whose last low cycle is in idle mode is also dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_space_n | input | 1 | High: common memory, low: attribute memory |
| host_en_lo_n | input | 1 | Active-low low-lane enable |
| host_en_hi_n | input | 1 | Active-low high-lane enable |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_addr | input | ADDR_W | Byte address; bit 0 selects the byte |
| host_din | input | 16 | Data from host |
| host_dout | output | 16 | Data to host |
| host_doe | output | 2 | Per-lane output enable (bit 1 = high lane) |
| arr_raddr | output | ADDR_W-1 | Array read word address |
| arr_rattr | output | 1 | Array read targets attribute storage |
| arr_rdata | input | 16 | Array read data |
| arr_we | output | 1 | One-cycle array write pulse |
| arr_waddr | output | ADDR_W-1 | Array write word address |
| arr_wattr | output | 1 | Array write targets attribute storage |
| arr_wdata | output | 16 | Array write data |
| arr_wstrb | output | 2 | Array byte write strobes |

## Verification
Reads are driven from a fixed set of vectors over every space and mode pair, each with host_addr[0] both low and high. Common and attribute words have different, position-dependent contents, so a swapped byte, an unignored address bit or a wrong lane enable gives a distinct value. Further vectors cover the disabled-output and illegal strobe combinations. Writes are issued in every mode and space, with the unused host_din byte set to a different value so that a wrong lane choice shows up in arr_wdata. These write tests also cover the dropped cases (odd attribute address, word-mode attribute, illegal strobes, idle) and check that the write pulse lasts exactly one cycle.

// File: rtl/card_lane_pkg.sv
package card_lane_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef enum logic [1:0] {
        LANE_BYTE = 2'd0,
        LANE_WORD = 2'd1,
        LANE_ODD  = 2'd2,
        LANE_IDLE = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/card_mode_decode.sv
module card_mode_decode
    import card_lane_pkg::*;
(
    input  logic       en_lo_n,
    input  logic       en_hi_n,
    output lane_mode_e mode
);
    always_comb begin
        unique case ({en_hi_n, en_lo_n})
            2'b10:   mode = LANE_BYTE;
            2'b00:   mode = LANE_WORD;
            2'b01:   mode = LANE_ODD;
            default: mode = LANE_IDLE;
        endcase
    end
endmodule

// File: rtl/card_rd_steer.sv
module card_rd_steer
    import card_lane_pkg::*;
(
    input  lane_mode_e              mode,
    input  logic                    attr,
    input  logic                    odd,
    input  logic                    rd_ok,
    input  logic [DATA_W-1:0]       rdata,
    output logic [DATA_W-1:0]       dout,
    output logic [LANES-1:0]        doe
);
    localparam logic [BYTE_W-1:0] FILL = '1;

    always_comb begin
        dout = '0;
        doe  = '0;
        if (rd_ok) begin
            unique case (mode)
                LANE_BYTE: begin
                    doe = 2'b01;
                    if (attr)
                        dout[BYTE_W-1:0] = odd ? FILL : rdata[BYTE_W-1:0];
                    else
                        dout[BYTE_W-1:0] = odd ? rdata[DATA_W-1:BYTE_W]
                                               : rdata[BYTE_W-1:0];
                end
                LANE_WORD: begin
                    if (attr) begin
                        doe              = 2'b01;
                        dout[BYTE_W-1:0] = rdata[BYTE_W-1:0];
                    end else begin
                        doe  = 2'b11;
                        dout = rdata;
                    end
                end
                LANE_ODD: begin
                    if (!attr) begin
                        doe                   = 2'b10;
                        dout[DATA_W-1:BYTE_W] = rdata[DATA_W-1:BYTE_W];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/card_wr_steer.sv
module card_wr_steer
    import card_lane_pkg::*;
(
    input  lane_mode_e              mode,
    input  logic                    attr,
    input  logic                    odd,
    input  logic                    rd_idle,
    input  logic [DATA_W-1:0]       din,
    output logic                    ok,
    output logic [DATA_W-1:0]       wdata,
    output logic [LANES-1:0]        wstrb
);
    always_comb begin
        ok    = 1'b0;
        wdata = '0;
        wstrb = '0;
        unique case (mode)
            LANE_BYTE: begin
                wdata = {din[BYTE_W-1:0], din[BYTE_W-1:0]};
                wstrb = odd ? 2'b10 : 2'b01;
                ok    = rd_idle && !(attr && odd);
            end
            LANE_WORD: begin
                wdata = din;
                wstrb = 2'b11;
                ok    = rd_idle && !attr;
            end
            LANE_ODD: begin
                wdata = {din[DATA_W-1:BYTE_W], din[DATA_W-1:BYTE_W]};
                wstrb = 2'b10;
                ok    = rd_idle && !attr;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/card_lane_steer.sv
module card_lane_steer
    import card_lane_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_space_n,
    input  logic                host_en_lo_n,
    input  logic                host_en_hi_n,
    input  logic                host_rd_n,
    input  logic                host_wr_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [15:0]         host_din,
    output logic [15:0]         host_dout,
    output logic [1:0]          host_doe,
    output logic [ADDR_W-2:0]   arr_raddr,
    output logic                arr_rattr,
    input  logic [15:0]         arr_rdata,
    output logic                arr_we,
    output logic [ADDR_W-2:0]   arr_waddr,
    output logic                arr_wattr,
    output logic [15:0]         arr_wdata,
    output logic [1:0]          arr_wstrb
);
    localparam int WORD_W = ADDR_W - 1;

    typedef struct packed {
        logic                wr_last;
        logic                pend;
        logic [WORD_W-1:0]   pend_addr;
        logic                pend_attr;
        logic [DATA_W-1:0]   pend_data;
        logic [LANES-1:0]    pend_strb;
        logic [DATA_W-1:0]   dout;
        logic [LANES-1:0]    doe;
        logic                we;
        logic [WORD_W-1:0]   waddr;
        logic                wattr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    wstrb;
    } steer_st_t;

    steer_st_t st_d, st_q;

    lane_mode_e          mode;
    logic                attr;
    logic                odd;
    logic [DATA_W-1:0]   rd_dout;
    logic [LANES-1:0]    rd_doe;
    logic                wr_ok;
    logic [DATA_W-1:0]   wr_data;
    logic [LANES-1:0]    wr_strb;

    assign attr      = ~host_space_n;
    assign odd       = host_addr[0];
    assign arr_raddr = host_addr[ADDR_W-1:1];
    assign arr_rattr = attr;

    card_mode_decode u_mode (
        .en_lo_n (host_en_lo_n),
        .en_hi_n (host_en_hi_n),
        .mode    (mode)
    );

    card_rd_steer u_rd (
        .mode  (mode),
        .attr  (attr),
        .odd   (odd),
        .rd_ok (~host_rd_n & host_wr_n),
        .rdata (arr_rdata),
        .dout  (rd_dout),
        .doe   (rd_doe)
    );

    card_wr_steer u_wr (
        .mode    (mode),
        .attr    (attr),
        .odd     (odd),
        .rd_idle (host_rd_n),
        .din     (host_din),
        .ok      (wr_ok),
        .wdata   (wr_data),
        .wstrb   (wr_strb)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wr_last = host_wr_n;
        st_d.dout    = rd_dout;
        st_d.doe     = rd_doe;
        st_d.we      = 1'b0;

        if (!host_wr_n) begin
            // last low cycle of the strobe decides what gets written
            st_d.pend      = wr_ok;
            st_d.pend_addr = host_addr[ADDR_W-1:1];
            st_d.pend_attr = attr;
            st_d.pend_data = wr_data;
            st_d.pend_strb = wr_strb;
        end else begin
            st_d.pend = 1'b0;
            if (!st_q.wr_last && st_q.pend) begin
                st_d.we    = 1'b1;
                st_d.waddr = st_q.pend_addr;
                st_d.wattr = st_q.pend_attr;
                st_d.wdata = st_q.pend_data;
                st_d.wstrb = st_q.pend_strb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{wr_last: 1'b1, default: '0};
        else
            st_q <= st_d;
    end

    assign host_dout = st_q.dout;
    assign host_doe  = st_q.doe;
    assign arr_we    = st_q.we;
    assign arr_waddr = st_q.waddr;
    assign arr_wattr = st_q.wattr;
    assign arr_wdata = st_q.wdata;
    assign arr_wstrb = st_q.wstrb;
endmodule

// File: rtl/card_lane_steer_chk.sv
module card_lane_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_space_n,
    input logic       host_en_lo_n,
    input logic       host_en_hi_n,
    input logic       host_rd_n,
    input logic       host_wr_n,
    input logic [1:0] host_doe,
    input logic       arr_we,
    input logic       arr_wattr,
    input logic [1:0] arr_wstrb
);
    // R5
    doe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_doe != 2'b00) |-> (!$past(host_rd_n) && $past(host_wr_n)));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_en_lo_n) && $past(host_en_hi_n)) |-> (host_doe == 2'b00));

    // R6
    attr_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_doe[1] |-> $past(host_space_n));

    // R7
    we_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ($past(host_wr_n) && !$past(host_wr_n, 2)));

    // R7
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);

    // R8
    attr_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && arr_wattr) |-> (arr_wstrb == 2'b01));

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_rd_n) == 1'b0 && $past(host_wr_n) == 1'b0) |-> (host_doe == 2'b00));
endmodule

bind card_lane_steer card_lane_steer_chk u_chk (.*);

// File: tb/card_lane_steer_tb.sv
module card_lane_steer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int NVEC       = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_space_n = 1'b1, host_en_lo_n = 1'b1, host_en_hi_n = 1'b1;
    logic host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic [1:0]  host_doe;
    logic [ADDR_W-2:0] arr_raddr, arr_waddr;
    logic arr_rattr, arr_we, arr_wattr;
    logic [15:0] arr_rdata, arr_wdata;
    logic [1:0]  arr_wstrb;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // array model: common word w = {80|w, 40|w}, attribute word w = {EE, 10|w}
    assign arr_rdata = arr_rattr ? {8'hEE, 8'h10 | 8'(arr_raddr)}
                                 : {8'h80 | 8'(arr_raddr), 8'h40 | 8'(arr_raddr)};

    card_lane_steer #(.ADDR_W(ADDR_W)) u_dut (.*);

    // {space_n, en_lo_n, en_hi_n, rd_n, wr_n, word[6:0], a0, exp_doe, exp_dout, req}
    localparam logic [34:0] VEC [NVEC] = '{
        {5'b10101, 7'd3, 1'b0, 2'b01, 16'h0043, 4'd2},  // R2 even byte
        {5'b10101, 7'd3, 1'b1, 2'b01, 16'h0083, 4'd2},  // R2 odd byte on low lane
        {5'b10001, 7'd5, 1'b0, 2'b11, 16'h8545, 4'd3},  // R3
        {5'b10001, 7'd5, 1'b1, 2'b11, 16'h8545, 4'd3},  // R3 A0 ignored
        {5'b11001, 7'd6, 1'b0, 2'b10, 16'h8600, 4'd4},  // R4
        {5'b11001, 7'd6, 1'b1, 2'b10, 16'h8600, 4'd4},  // R4 A0 ignored
        {5'b11101, 7'd6, 1'b0, 2'b00, 16'h0000, 4'd5},  // R5 idle
        {5'b10111, 7'd3, 1'b0, 2'b00, 16'h0000, 4'd5},  // R5 output disabled
        {5'b00101, 7'd2, 1'b0, 2'b01, 16'h0012, 4'd6},  // R6 attr byte even
        {5'b00101, 7'd2, 1'b1, 2'b01, 16'h00FF, 4'd6},  // R6 attr byte odd -> FF
        {5'b00001, 7'd7, 1'b1, 2'b01, 16'h0017, 4'd6},  // R6 attr word
        {5'b01001, 7'd7, 1'b0, 2'b00, 16'h0000, 4'd6},  // R6 attr odd mode
        {5'b10000, 7'd5, 1'b0, 2'b00, 16'h0000, 4'd9},  // R9 illegal strobes
        {5'b01101, 7'd2, 1'b0, 2'b00, 16'h0000, 4'd5},  // R5 attr idle
        {5'b10101, 7'd9, 1'b1, 2'b01, 16'h0089, 4'd2},  // R2 other word
        {5'b10001, 7'd0, 1'b0, 2'b11, 16'h8040, 4'd3}   // R3 word 0
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        host_space_n = 1'b1; host_en_lo_n = 1'b1; host_en_hi_n = 1'b1;
        host_rd_n = 1'b1; host_wr_n = 1'b1;
    endtask

    task automatic do_write(input logic sp, input logic lo, input logic hi, input logic rd,
                            input logic [6:0] w, input logic a0, input logic [15:0] din,
                            input int req, input logic exp_we,
                            input logic [1:0] exp_strb, input logic [15:0] exp_wd);
        @(negedge clk);
        host_space_n = sp; host_en_lo_n = lo; host_en_hi_n = hi;
        host_rd_n = rd; host_wr_n = 1'b0;
        host_addr = {w, a0}; host_din = din;
        @(negedge clk);
        host_wr_n = 1'b1;
        check(req, "no pulse while strobe low", {31'd0, arr_we}, 32'd0);
        @(negedge clk);
        if (exp_we)
            check(req, "write {we,attr,addr,strb,data}",
                  {5'd0, arr_we, arr_wattr, arr_waddr, arr_wstrb, arr_wdata},
                  {5'd0, 1'b1, ~sp, w, exp_strb, exp_wd});
        else
            check(req, "write dropped", {31'd0, arr_we}, 32'd0);
        go_idle();
        @(negedge clk);
        check(7, "pulse lasts one cycle", {31'd0, arr_we}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL R1 watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(1, "doe in reset", {30'd0, host_doe}, 32'd0);
        check(1, "dout in reset", {16'd0, host_dout}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "we after reset", {31'd0, arr_we}, 32'd0);
        check(1, "doe after reset", {30'd0, host_doe}, 32'd0);

        // read vectors
        for (int i = 0; i < NVEC; i++) begin
            logic [34:0] v;
            v = VEC[i];
            @(negedge clk);
            {host_space_n, host_en_lo_n, host_en_hi_n, host_rd_n, host_wr_n} = v[34:30];
            host_addr = {v[29:23], v[22]};
            @(negedge clk);
            check(int'(v[3:0]), $sformatf("read vec %0d {doe,dout}", i),
                  {14'd0, host_doe, host_dout}, {14'd0, v[21:20], v[19:4]});
        end
        @(negedge clk);
        go_idle();

        // R7 common writes in each mode
        do_write(1'b1, 1'b0, 1'b1, 1'b1, 7'd9, 1'b1, 16'h5AA5, 7, 1'b1, 2'b10, 16'hA5A5);
        do_write(1'b1, 1'b0, 1'b1, 1'b1, 7'd9, 1'b0, 16'h5AC3, 7, 1'b1, 2'b01, 16'hC3C3);
        do_write(1'b1, 1'b0, 1'b0, 1'b1, 7'd4, 1'b1, 16'h1234, 7, 1'b1, 2'b11, 16'h1234);
        do_write(1'b1, 1'b1, 1'b0, 1'b1, 7'd8, 1'b0, 16'h77C4, 7, 1'b1, 2'b10, 16'h7777);
        // R8 attribute writes
        do_write(1'b0, 1'b0, 1'b1, 1'b1, 7'd2, 1'b0, 16'h993C, 8, 1'b1, 2'b01, 16'h3C3C);
        do_write(1'b0, 1'b0, 1'b1, 1'b1, 7'd2, 1'b1, 16'h993C, 8, 1'b0, 2'b00, 16'h0000);
        do_write(1'b0, 1'b0, 1'b0, 1'b1, 7'd2, 1'b0, 16'h993C, 8, 1'b0, 2'b00, 16'h0000);
        do_write(1'b0, 1'b1, 1'b0, 1'b1, 7'd2, 1'b0, 16'h993C, 8, 1'b0, 2'b00, 16'h0000);
        // R9 illegal strobes and idle mode
        do_write(1'b1, 1'b0, 1'b0, 1'b0, 7'd4, 1'b0, 16'hBEEF, 9, 1'b0, 2'b00, 16'h0000);
        do_write(1'b1, 1'b1, 1'b1, 1'b1, 7'd4, 1'b0, 16'hBEEF, 9, 1'b0, 2'b00, 16'h0000);
        // legal write after the dropped ones still goes through
        do_write(1'b1, 1'b0, 1'b0, 1'b1, 7'd1, 1'b0, 16'hCAFE, 7, 1'b1, 2'b11, 16'hCAFE);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule